// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Latch

This block is the interrupt front end of a small controller. It serves two sources. The first is an external pin that is not synchronous to the clock. The second is a timer overflow strobe. Each source latches into its own request flag, so a short event is never lost while interrupts are disabled. A global enable flag decides when a pending request is accepted. All state advances only on clocks where the instruction-cycle enable `cyc_en` is high. The pin synchronizer is the one exception and runs on every clock.

When a request is accepted, the block raises `irq_take` for one clock and reports the winning source on `irq_src`. In the same step it clears the global enable and the request flag of the winning source. The external pin always wins over the timer. A timer request that loses stays pending until software sets the enable again.

The enable reaches the accept logic through a register that is one instruction cycle late. Software can also set or clear the enable, and can clear either request flag. It can read the synchronized pin level and all three flags, so the pin also serves as a latched general-purpose input.

Top module: `irq_front`

## Requirements
- R1: A 0-to-1 change of the synchronized pin level is judged between two consecutive instruction cycles. Such a change sets `st_ext_rq` at the second of those cycles. A pin that stays high, or that falls, sets nothing.
- R2: `tmr_stb` high on an instruction cycle sets `st_tmr_rq`.
- R3: On an instruction cycle, `ien_set` sets `st_ien` and `ien_clr` clears it; when both are high, set wins. An acceptance clears `st_ien` and wins over `ien_set`.
- R4: A request is accepted on an instruction cycle when three things hold: the enable flag is 1, the enable flag was already 1 at the previous instruction cycle, and at least one request flag is 1. `irq_take` is then high for exactly one clock, on the clock that follows.
- R5: `irq_src` is 0 for the external pin and 1 for the timer. When both flags are 1, the external pin is accepted, and `st_tmr_rq` stays 1 until a later acceptance.
- R6: An acceptance clears only the request flag of the source it selects.
- R7: On each request flag, a set on the same instruction cycle as a clear leaves the flag at 1. This covers both a software clear and an acceptance clear.
- R8: After `ien_set` on instruction cycle n, with a request already pending, the earliest acceptance happens on instruction cycle n+2.
- R9: `st_pin` follows `ext_pin` after `SYNC_STAGES` clocks, whatever the value of `cyc_en`.
- R10: Synchronous `rst` clears all flags and `irq_take`, so the block starts with interrupts disabled.
- R11: On clocks with `cyc_en` low, no flag changes and no acceptance happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Instruction-cycle enable |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr_stb | input | 1 | Timer overflow strobe |
| ien_set | input | 1 | Set the global enable |
| ien_clr | input | 1 | Clear the global enable |
| clr_ext | input | 1 | Clear the external request flag |
| clr_tmr | input | 1 | Clear the timer request flag |
| irq_take | output | 1 | One-clock interrupt-accepted pulse |
| irq_src | output | 1 | Accepted source: 0 pin, 1 timer |
| st_pin | output | 1 | Synchronized pin level |
| st_ext_rq | output | 1 | External request flag |
| st_tmr_rq | output | 1 | Timer request flag |
| st_ien | output | 1 | Global enable flag |

## Verification
The flags and `st_ien` change at the edge of the instruction cycle that sets or clears them. `irq_take` and `irq_src` appear one clock after the accepting edge. A pin edge takes `SYNC_STAGES` clocks to reach `st_pin`, and is then judged on the next instruction cycle. A behavioural reference model in the bench applies these delays on every clock edge. Every output is compared at the falling edge, half a clock after the sampling edge. The directed checks are placed at the end of whole instruction cycles, so they always sample after every due update has taken place.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
    localparam int NUM_SRC = 2;
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;

    typedef struct packed {
        logic             take;
        logic [SRC_W-1:0] src;
    } grant_t;

    typedef struct packed {
        logic ien;
        logic ien_dly;
    } ien_st_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_en,
    input  logic pin_async,
    output logic pin_sync,
    output logic rise
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = pin_async;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        if (cyc_en) begin
            st_d.prev = st_q.sync[SYNC_STAGES-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.sync[SYNC_STAGES-1];
    assign rise     = cyc_en & st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/irq_req_flag.sv
module irq_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    // set dominates clear
    always_comb begin
        flag_d = set | (flag_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_front_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cyc_en,
    input  logic               ien_set,
    input  logic               ien_clr,
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] accept,
    output logic               take,
    output logic [SRC_W-1:0]   src,
    output logic               ien
);
    typedef struct packed {
        ien_st_t en;
        grant_t  out;
    } ctrl_st_t;

    ctrl_st_t   st_d, st_q;
    logic       grant;
    logic [SRC_W-1:0] win;

    always_comb begin
        // lowest index has the highest priority
        win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = SRC_W'(i);
            end
        end
        grant  = cyc_en & st_q.en.ien & st_q.en.ien_dly & (|req);
        accept = '0;
        if (grant) begin
            accept[win] = 1'b1;
        end

        st_d          = st_q;
        st_d.out.take = grant;
        if (grant) begin
            st_d.out.src = win;
        end
        if (cyc_en) begin
            st_d.en.ien_dly = st_q.en.ien;
        end
        if (grant) begin
            st_d.en.ien = 1'b0;
        end else if (cyc_en && ien_set) begin
            st_d.en.ien = 1'b1;
        end else if (cyc_en && ien_clr) begin
            st_d.en.ien = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take = st_q.out.take;
    assign src  = st_q.out.src;
    assign ien  = st_q.en.ien;
endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_front_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_en,
    input  logic ext_pin,
    input  logic tmr_stb,
    input  logic ien_set,
    input  logic ien_clr,
    input  logic clr_ext,
    input  logic clr_tmr,
    output logic irq_take,
    output logic irq_src,
    output logic st_pin,
    output logic st_ext_rq,
    output logic st_tmr_rq,
    output logic st_ien
);
    logic               ext_rise;
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] sw_clr;
    logic [NUM_SRC-1:0] src_clr;
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] accept;
    logic [SRC_W-1:0]   win_src;

    irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .cyc_en   (cyc_en),
        .pin_async(ext_pin),
        .pin_sync (st_pin),
        .rise     (ext_rise)
    );

    assign src_set[SRC_EXT] = ext_rise;
    assign src_set[SRC_TMR] = cyc_en & tmr_stb;
    assign sw_clr[SRC_EXT]  = clr_ext;
    assign sw_clr[SRC_TMR]  = clr_tmr;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        assign src_clr[g] = (cyc_en & sw_clr[g]) | accept[g];
        irq_req_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (src_set[g]),
            .clr (src_clr[g]),
            .flag(req[g])
        );
    end

    irq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cyc_en (cyc_en),
        .ien_set(ien_set),
        .ien_clr(ien_clr),
        .req    (req),
        .accept (accept),
        .take   (irq_take),
        .src    (win_src),
        .ien    (st_ien)
    );

    assign irq_src   = win_src[0];
    assign st_ext_rq = req[SRC_EXT];
    assign st_tmr_rq = req[SRC_TMR];
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
    input logic clk,
    input logic rst,
    input logic cyc_en,
    input logic irq_take,
    input logic irq_src,
    input logic st_ext_rq,
    input logic st_tmr_rq,
    input logic st_ien
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!st_ien && !st_ext_rq && !st_tmr_rq && !irq_take)); // R10
    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take); // R4
    AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_take) |-> $past(st_ext_rq || st_tmr_rq)); // R4
    AST_TAKE_DROPS_IEN: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> !st_ien); // R3
    AST_PIN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (irq_take && irq_src) |-> !$past(st_ext_rq)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> ($stable(st_ien) && $stable(st_ext_rq) && $stable(st_tmr_rq) && !irq_take)); // R11
endmodule

bind irq_front irq_front_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_en   (cyc_en),
    .irq_take (irq_take),
    .irq_src  (irq_src),
    .st_ext_rq(st_ext_rq),
    .st_tmr_rq(st_tmr_rq),
    .st_ien   (st_ien)
);

// File: tb/irq_front_tb_top.sv
`timescale 1ns/1ps
module irq_front_tb_top;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_en = 0, ext_pin = 0, tmr_stb = 0, ien_set = 0, ien_clr = 0;
    logic clr_ext = 0, clr_tmr = 0;
    logic irq_take, irq_src, st_pin, st_ext_rq, st_tmr_rq, st_ien;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_front #(.SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .tmr_stb(tmr_stb), .ien_set(ien_set), .ien_clr(ien_clr),
        .clr_ext(clr_ext), .clr_tmr(clr_tmr), .irq_take(irq_take),
        .irq_src(irq_src), .st_pin(st_pin), .st_ext_rq(st_ext_rq),
        .st_tmr_rq(st_tmr_rq), .st_ien(st_ien)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit pin_line[$];
    bit m_live = 0;
    bit m_prev, m_ext, m_tmr, m_ien, m_ien_old, m_take, m_src;
    always @(posedge clk) begin
        bit seen, rise, fire, pick_tmr, n_ext, n_tmr, n_ien;
        if (rst) begin
            {m_prev, m_ext, m_tmr, m_ien, m_ien_old, m_take, m_src} = '0;
            pin_line.delete();
            repeat (SYNC) pin_line.push_back(1'b0);
            m_live = 1;
        end else begin
            seen     = pin_line[$];
            rise     = cyc_en && seen && !m_prev;
            fire     = cyc_en && m_ien && m_ien_old && (m_ext || m_tmr);
            pick_tmr = !m_ext;
            n_ext = rise || (m_ext && !(cyc_en && clr_ext) && !(fire && !pick_tmr));
            n_tmr = (cyc_en && tmr_stb) || (m_tmr && !(cyc_en && clr_tmr) && !(fire && pick_tmr));
            if (fire) n_ien = 0;
            else if (cyc_en && ien_set) n_ien = 1;
            else if (cyc_en && ien_clr) n_ien = 0;
            else n_ien = m_ien;
            if (cyc_en) begin
                m_ien_old = m_ien;
                m_prev    = seen;
            end
            m_ext  = n_ext;
            m_tmr  = n_tmr;
            m_ien  = n_ien;
            m_take = fire;
            if (fire) m_src = pick_tmr;
            pin_line.push_front(ext_pin);
            void'(pin_line.pop_back());
        end
    end

    always @(negedge clk) begin
        if (m_live && !finished) begin
            chk("R4 irq_take", irq_take, m_take);
            chk("R5 irq_src", irq_src, m_src);
            chk("R1 st_ext_rq", st_ext_rq, m_ext);
            chk("R2 st_tmr_rq", st_tmr_rq, m_tmr);
            chk("R3 st_ien", st_ien, m_ien);
            chk("R9 st_pin", st_pin, pin_line[$]);
        end
    end

    bit take_log[$];
    always @(negedge clk) begin
        if (!rst && irq_take) take_log.push_back(irq_src);
    end

    task automatic run_ic(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cyc_en = 1;
            @(negedge clk); cyc_en = 0;
            ien_set = 0; ien_clr = 0; clr_ext = 0; clr_tmr = 0; tmr_stb = 0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10 ien after reset", st_ien, 0);
        chk("R10 flags after reset", st_ext_rq + st_tmr_rq + irq_take, 0);

        // R9 synchronizer latency
        ext_pin = 1;
        @(negedge clk);
        chk("R9 pin after 1 clk", st_pin, 0);
        @(negedge clk);
        chk("R9 pin after 2 clk", st_pin, 1);

        // R1 latched while disabled
        run_ic(2);
        chk("R1 ext flag set", st_ext_rq, 1);
        chk("R1 no take while disabled", take_log.size(), 0);
        run_ic(2);
        chk("R1 steady high no new edge", st_ext_rq, 1);

        // R8 delayed enable
        ien_set = 1;
        run_ic(1);
        chk("R3 ien set", st_ien, 1);
        run_ic(1);
        chk("R8 no take one ic after set", take_log.size(), 0);
        run_ic(1);
        chk("R8 take at second ic", take_log.size(), 1);
        chk("R4 src pin", take_log[0], 0);
        chk("R6 ext flag cleared", st_ext_rq, 0);
        chk("R3 ien cleared by take", st_ien, 0);

        // R5 simultaneous sources
        ext_pin = 0;
        run_ic(2);
        ext_pin = 1; tmr_stb = 1;
        run_ic(3);
        chk("R2 tmr flag set", st_tmr_rq, 1);
        ien_set = 1;
        run_ic(3);
        chk("R5 pin wins", take_log.size() == 2 && take_log[1] == 0, 1);
        chk("R5 timer stays pending", st_tmr_rq, 1);
        ien_set = 1;
        run_ic(3);
        chk("R5 timer served later", take_log.size() == 3 && take_log[2] == 1, 1);
        chk("R6 timer flag cleared", st_tmr_rq, 0);

        // R7 set beats clear
        tmr_stb = 1; clr_tmr = 1;
        run_ic(1);
        chk("R7 set over clear", st_tmr_rq, 1);
        clr_tmr = 1;
        run_ic(1);
        chk("R7 clear alone", st_tmr_rq, 0);

        // R3 set beats clear on enable
        ien_set = 1; ien_clr = 1;
        run_ic(1);
        chk("R3 set over clr", st_ien, 1);
        ien_clr = 1;
        run_ic(1);
        chk("R3 clr", st_ien, 0);

        // R11 controls ignored without cyc_en
        @(negedge clk);
        ien_set = 1; tmr_stb = 1; ext_pin = 0;
        repeat (4) @(negedge clk);
        chk("R11 ien held", st_ien, 0);
        chk("R11 tmr held", st_tmr_rq, 0);
        ien_set = 0; tmr_stb = 0;

        // random mix, model compared every clock
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            cyc_en  = ($urandom % 3) == 0;
            ien_set = ($urandom % 6) == 0;
            ien_clr = ($urandom % 12) == 0;
            tmr_stb = ($urandom % 15) == 0;
            clr_ext = ($urandom % 20) == 0;
            clr_tmr = ($urandom % 20) == 0;
            if (($urandom % 9) == 0) ext_pin = ~ext_pin;
        end
        cyc_en = 0; ien_set = 0; ien_clr = 0; tmr_stb = 0; clr_ext = 0; clr_tmr = 0;
        repeat (4) @(negedge clk);
        summary();
    end
endmodule